// File: doc/BRIEF.md
# NAND Page Array with Program and Erase

This block is the storage back end of a small-page NAND model kept in on-chip registers. The array is a set of pages. Each page has a main area of `PAGE_BYTES` bytes and a spare area that is one thirty-second of that size. Pages are grouped into erase blocks of `2**PPB_LOG2` pages. A command decoder in front of the block drives one shared page and column operand. It can load a page into the page register from any column, fill a write buffer, program that buffer into a page, or erase a whole block.

Reads are streamed from the page register, one byte per strobe. When the page register runs dry, the next strobe fetches the following page and starts at the same column where the last load began. Reads therefore run on across page boundaries until the last page is passed. Program is a bitwise AND with the stored bytes, so it can only clear bits. Only erase can set bits back to one. Program and erase each raise `busy` for a fixed number of cycles and then pulse `done`.

Top module: `nand_page_store`

## Requirements
- R1: Each page row is `PAGE_BYTES + PAGE_BYTES/32` bytes long, with the main bytes at columns 0 to `PAGE_BYTES-1` and the spare bytes after them. After reset every cell reads 0xFF, and `busy`, `done`, `rd_left` and `wbuf_count` are 0.
- R2: A `wbuf_push` stores `wbuf_byte` and increments `wbuf_count` only while the count is below the row length; further bytes are dropped. `wbuf_clear` or an accepted program empties the buffer.
- R3: An accepted program ANDs buffer byte i into column `op_col + i` of page `op_page`, for every i below `wbuf_count` with `op_col + i` below the row length. Buffered bytes beyond the row end are dropped.
- R4: An accepted erase sets every byte of every page whose index shifted right by `PPB_LOG2` equals that of `op_page` to 0xFF. Pages in other blocks are left unchanged.
- R5: An accepted load copies row `op_page` into the page register and sets `rd_left` to the row length minus `op_col`. A load with `op_col` at or past the row length is ignored.
- R6: A `rd_strobe` with `rd_left` nonzero presents the byte at the read pointer on `rd_data`, with `rd_valid` high, in the next cycle. It then advances the pointer and decrements `rd_left`.
- R7: A `rd_strobe` with `rd_left` at 0 loads the next page, starting at the column of the last load, and returns that byte at once. `rd_left` then becomes the row length minus that column minus one. After reset the next page is page 0 and the column is 0.
- R8: A strobe with `rd_left` at 0 when the next page is at or beyond `NUM_PAGES` returns 0x00 and leaves `rd_left` at 0.
- R9: A program, erase or load whose `op_page` is at or beyond `NUM_PAGES` is ignored. It raises no `busy`, changes no cell, and leaves the write buffer and the read state as they were.
- R10: An accepted program or erase holds `busy` high for exactly `BUSY_CYCLES` cycles, beginning with the cycle after the request. `done` is high for the single cycle after that.
- R11: While `busy` is high, program, erase and load requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wbuf_push | input | 1 | Append `wbuf_byte` to the write buffer |
| wbuf_byte | input | 8 | Program data byte |
| wbuf_clear | input | 1 | Empty the write buffer |
| prog_req | input | 1 | Program request (loses to erase) |
| erase_req | input | 1 | Erase the block that holds `op_page` |
| load_req | input | 1 | Load request (loses to program and erase) |
| op_page | input | PAGE_W | Page index operand |
| op_col | input | COL_W | Column operand for load and program |
| rd_strobe | input | 1 | Read one byte from the page register |
| rd_data | output | 8 | Byte returned by the last strobe |
| rd_valid | output | 1 | `rd_data` was updated by a strobe in the previous cycle |
| rd_left | output | COL_W | Bytes remaining in the page register |
| wbuf_count | output | COL_W | Bytes held in the write buffer |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle pulse when the busy time ends |

## Verification
The bench writes the buffer past the row end and checks that the count stops at the row length. A design that lets the count run on would corrupt the next page on program. It programs the same page twice with overlapping columns and checks the AND result; an overwrite would show the second pattern where the first had already cleared bits. It starts a load near the row end and reads on through two reloads and past the last page. This catches a reload that restarts at column 0, loses a byte, or keeps streaming old data. It also gives out-of-range page indices and requests during busy, then sweeps the whole array after erases of both blocks. A wrong block mask would wipe or keep the wrong pages.

// File: rtl/nandst_pkg.sv
package nandst_pkg;
   // Operation accepted in a given cycle, in priority order.
   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_LOAD  = 2'd1,
      OPK_PROG  = 2'd2,
      OPK_ERASE = 2'd3
   } opk_e;

   function automatic int spare_bytes(input int main_bytes);
      return main_bytes / 32;
   endfunction

   function automatic int row_bytes(input int main_bytes);
      return main_bytes + spare_bytes(main_bytes);
   endfunction
endpackage

// File: rtl/nand_write_buf.sv
module nand_write_buf #(
   parameter int TOT   = 66,
   parameter int COL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [7:0]       din,
   input  logic             clear,
   input  logic             consume,
   output logic [7:0]       row [TOT],
   output logic [COL_W-1:0] fill
);
   localparam logic [COL_W-1:0] FULL = COL_W'(TOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill <= '0;
         for (int i = 0; i < TOT; i++) row[i] <= 8'hFF;
      end else if (clear || consume) begin
         fill <= '0;
      end else if (push && fill < FULL) begin
         row[fill] <= din;
         fill      <= fill + 1'b1;
      end
   end

   // R2
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clear && !consume && fill == FULL) |=> fill == FULL);
   // R2
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL);
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
   parameter int PPB_LOG2  = 2,
   parameter int NUM_PAGES = 16,
   parameter int TOT       = 66,
   parameter int COL_W     = 7,
   parameter int PAGE_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              erase_en,
   input  logic [PAGE_W-1:0] op_page,
   input  logic [COL_W-1:0]  op_col,
   input  logic [7:0]        wb_row [TOT],
   input  logic [COL_W-1:0]  wb_fill,
   input  logic [PAGE_W-1:0] rd_page,
   output logic [7:0]        rd_row [TOT]
);
   localparam int CELLS = NUM_PAGES * TOT;

   logic [7:0] mem [CELLS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < CELLS; k++) mem[k] <= 8'hFF;
      end else if (erase_en) begin
         for (int p = 0; p < NUM_PAGES; p++) begin
            if ((p >> PPB_LOG2) == (int'(op_page) >> PPB_LOG2)) begin
               for (int c = 0; c < TOT; c++) mem[p*TOT + c] <= 8'hFF;
            end
         end
      end else if (prog_en) begin
         for (int c = 0; c < TOT; c++) begin
            if (c >= int'(op_col) && (c - int'(op_col)) < int'(wb_fill)) begin
               mem[int'(op_page)*TOT + c] <=
                  mem[int'(op_page)*TOT + c] & wb_row[c - int'(op_col)];
            end
         end
      end
   end

   always_comb begin
      for (int c = 0; c < TOT; c++) begin
         rd_row[c] = (int'(rd_page) < NUM_PAGES) ? mem[int'(rd_page)*TOT + c] : 8'hFF;
      end
   end

   // R4
   erase_base_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |=> mem[((int'($past(op_page)) >> PPB_LOG2) << PPB_LOG2) * TOT] == 8'hFF);
endmodule

// File: rtl/nand_op_timer.sv
module nand_op_timer #(
   parameter int BUSY_CYCLES = 8,
   parameter int CNT_W       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= (cnt == CNT_W'(1));
         if (start && cnt == '0) cnt <= CNT_W'(BUSY_CYCLES);
         else if (cnt != '0)     cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R10
   fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/nand_page_reg.sv
module nand_page_reg #(
   parameter int NUM_PAGES = 16,
   parameter int TOT       = 66,
   parameter int COL_W     = 7,
   parameter int PAGE_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [PAGE_W-1:0] load_page,
   input  logic [COL_W-1:0]  load_col,
   input  logic              strobe,
   input  logic [7:0]        row [TOT],
   output logic [PAGE_W-1:0] nxt_page,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic [COL_W-1:0]  rd_left
);
   localparam logic [COL_W-1:0]  ROW_LEN = COL_W'(TOT);
   localparam logic [PAGE_W-1:0] LAST_NX = PAGE_W'(NUM_PAGES);

   logic [7:0]       preg [TOT];
   logic [COL_W-1:0] ptr;
   logic [COL_W-1:0] base_col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TOT; i++) preg[i] <= 8'hFF;
         ptr      <= '0;
         base_col <= '0;
         nxt_page <= '0;
         rd_left  <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else if (load_en) begin
         for (int i = 0; i < TOT; i++) preg[i] <= row[i];
         ptr      <= load_col;
         base_col <= load_col;
         rd_left  <= ROW_LEN - load_col;
         nxt_page <= load_page + 1'b1;
         rd_valid <= 1'b0;
      end else if (strobe) begin
         rd_valid <= 1'b1;
         if (rd_left != '0) begin
            rd_data <= preg[ptr];
            ptr     <= ptr + 1'b1;
            rd_left <= rd_left - 1'b1;
         end else if (nxt_page < LAST_NX) begin
            for (int i = 0; i < TOT; i++) preg[i] <= row[i];
            rd_data  <= row[base_col];
            ptr      <= base_col + 1'b1;
            rd_left  <= ROW_LEN - base_col - 1'b1;
            nxt_page <= nxt_page + 1'b1;
         end else begin
            rd_data <= 8'h00;
         end
      end else begin
         rd_valid <= 1'b0;
      end
   end

   // R6
   left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !load_en && rd_left != '0) |=> rd_left == $past(rd_left) - 1'b1);
   // R7
   reload_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !load_en && rd_left == '0 && nxt_page < LAST_NX)
      |=> rd_left == ROW_LEN - $past(base_col) - 1'b1);
   // R8
   past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !load_en && rd_left == '0 && nxt_page >= LAST_NX)
      |=> (rd_data == 8'h00 && rd_left == '0));
   // R6
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(strobe));
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
   import nandst_pkg::*;
#(
   parameter int PAGE_BYTES  = 64,
   parameter int PPB_LOG2    = 2,
   parameter int NUM_PAGES   = 16,
   parameter int BUSY_CYCLES = 8,
   parameter int TOT         = row_bytes(PAGE_BYTES),
   parameter int COL_W       = $clog2(TOT + 1),
   parameter int PAGE_W      = $clog2(NUM_PAGES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wbuf_push,
   input  logic [7:0]        wbuf_byte,
   input  logic              wbuf_clear,
   input  logic              prog_req,
   input  logic              erase_req,
   input  logic              load_req,
   input  logic [PAGE_W-1:0] op_page,
   input  logic [COL_W-1:0]  op_col,
   input  logic              rd_strobe,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic [COL_W-1:0]  rd_left,
   output logic [COL_W-1:0]  wbuf_count,
   output logic              busy,
   output logic              done
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [PAGE_W-1:0] PG_LIM = PAGE_W'(NUM_PAGES);
   localparam logic [COL_W-1:0]  COL_LIM = COL_W'(TOT);

   generate
      if (PAGE_BYTES < 32 || (PAGE_BYTES % 32) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a positive multiple of 32");
      end
      if ((NUM_PAGES % (1 << PPB_LOG2)) != 0) begin : g_bad_blk
         $error("NUM_PAGES must be a whole number of erase blocks");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (TOT != row_bytes(PAGE_BYTES)) begin : g_bad_tot
         $error("TOT must not be overridden");
      end
   endgenerate

   opk_e        op_acc;
   logic        page_ok;
   logic        col_ok;
   logic [7:0]  wb_row  [TOT];
   logic [7:0]  arr_row [TOT];
   logic [PAGE_W-1:0] nxt_page;
   logic [PAGE_W-1:0] row_sel;

   assign page_ok = (op_page < PG_LIM);
   assign col_ok  = (op_col < COL_LIM);

   always_comb begin
      op_acc = OPK_NONE;
      if (!busy && page_ok) begin
         if (erase_req)               op_acc = OPK_ERASE;
         else if (prog_req)           op_acc = OPK_PROG;
         else if (load_req && col_ok) op_acc = OPK_LOAD;
      end
   end

   assign row_sel = (op_acc == OPK_LOAD) ? op_page : nxt_page;

   nand_write_buf #(.TOT(TOT), .COL_W(COL_W)) u_wbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (wbuf_push),
      .din     (wbuf_byte),
      .clear   (wbuf_clear),
      .consume (op_acc == OPK_PROG),
      .row     (wb_row),
      .fill    (wbuf_count)
   );

   nand_cell_array #(
      .PPB_LOG2 (PPB_LOG2), .NUM_PAGES(NUM_PAGES), .TOT(TOT),
      .COL_W    (COL_W),    .PAGE_W   (PAGE_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_en  (op_acc == OPK_PROG),
      .erase_en (op_acc == OPK_ERASE),
      .op_page  (op_page),
      .op_col   (op_col),
      .wb_row   (wb_row),
      .wb_fill  (wbuf_count),
      .rd_page  (row_sel),
      .rd_row   (arr_row)
   );

   nand_page_reg #(
      .NUM_PAGES(NUM_PAGES), .TOT(TOT), .COL_W(COL_W), .PAGE_W(PAGE_W)
   ) u_preg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (op_acc == OPK_LOAD),
      .load_page (op_page),
      .load_col  (op_col),
      .strobe    (rd_strobe),
      .row       (arr_row),
      .nxt_page  (nxt_page),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .rd_left   (rd_left)
   );

   nand_op_timer #(.BUSY_CYCLES(BUSY_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (op_acc == OPK_PROG || op_acc == OPK_ERASE),
      .busy  (busy),
      .done  (done)
   );

   // R9
   range_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (prog_req || erase_req) && !page_ok) |=> !busy);
   // R11
   busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load_req && !rd_strobe) |=> $stable(rd_left));
endmodule

// File: tb/nand_page_store_bench.sv
module nand_page_store_bench;
   localparam int PB    = 32;
   localparam int PPBL  = 1;
   localparam int NP    = 4;
   localparam int BC    = 3;
   localparam int TOT   = PB + PB/32;
   localparam int COL_W = $clog2(TOT + 1);
   localparam int PG_W  = $clog2(NP) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wbuf_push = 1'b0, wbuf_clear = 1'b0;
   logic [7:0] wbuf_byte = '0;
   logic prog_req = 1'b0, erase_req = 1'b0, load_req = 1'b0, rd_strobe = 1'b0;
   logic [PG_W-1:0]  op_page = '0;
   logic [COL_W-1:0] op_col = '0;
   logic [7:0] rd_data;
   logic rd_valid, busy, done;
   logic [COL_W-1:0] rd_left, wbuf_count;

   int n_chk = 0, n_bad = 0;
   logic [7:0] model [NP*TOT];
   logic [7:0] wq [TOT];
   int wcnt = 0;

   always #2.5 clk = ~clk;

   nand_page_store #(.PAGE_BYTES(PB), .PPB_LOG2(PPBL), .NUM_PAGES(NP),
                     .BUSY_CYCLES(BC)) u_nand_page_store (
      .clk(clk), .rst_n(rst_n), .wbuf_push(wbuf_push), .wbuf_byte(wbuf_byte),
      .wbuf_clear(wbuf_clear), .prog_req(prog_req), .erase_req(erase_req),
      .load_req(load_req), .op_page(op_page), .op_col(op_col),
      .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_left(rd_left), .wbuf_count(wbuf_count), .busy(busy), .done(done));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed*53 + i*29 + 7) & 255);
   endfunction

   task automatic push_n(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wbuf_push = 1'b1; wbuf_byte = pat(seed, i);
         if (wcnt < TOT) begin wq[wcnt] = pat(seed, i); wcnt++; end
      end
      @(negedge clk); wbuf_push = 1'b0;
   endtask

   task automatic wait_op(input bit started);
      if (started) begin
         for (int k = 0; k < BC; k++) begin
            chk("R10 busy held", int'(busy), 1);
            @(negedge clk);
         end
         chk("R10 busy end", int'(busy), 0);
         chk("R10 done pulse", int'(done), 1);
         @(negedge clk);
         chk("R10 done one cycle", int'(done), 0);
      end else begin
         for (int k = 0; k < 3; k++) begin
            chk("R9 no busy", int'(busy), 0);
            @(negedge clk);
         end
      end
   endtask

   task automatic do_prog(input int pg, input int col);
      @(negedge clk); prog_req = 1'b1; op_page = PG_W'(pg); op_col = COL_W'(col);
      @(negedge clk); prog_req = 1'b0;
      if (pg < NP) begin
         for (int c = col; c < TOT; c++)
            if (c - col < wcnt) model[pg*TOT + c] &= wq[c - col];
         wcnt = 0;
      end
      wait_op(pg < NP);
   endtask

   task automatic do_erase(input int pg);
      @(negedge clk); erase_req = 1'b1; op_page = PG_W'(pg);
      @(negedge clk); erase_req = 1'b0;
      if (pg < NP)
         for (int p = 0; p < NP; p++)
            if ((p >> PPBL) == (pg >> PPBL))
               for (int c = 0; c < TOT; c++) model[p*TOT + c] = 8'hFF;
      wait_op(pg < NP);
   endtask

   task automatic do_load(input int pg, input int col);
      @(negedge clk); load_req = 1'b1; op_page = PG_W'(pg); op_col = COL_W'(col);
      @(negedge clk); load_req = 1'b0;
   endtask

   task automatic strobe(input string req, input int exp, input int exp_left);
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
      chk({req, " valid"}, int'(rd_valid), 1);
      chk({req, " data"}, int'(rd_data), exp);
      chk({req, " left"}, int'(rd_left), exp_left);
   endtask

   task automatic sweep_all();
      do_load(0, 0);
      chk("R5 sweep left", int'(rd_left), TOT);
      for (int p = 0; p < NP; p++)
         for (int c = 0; c < TOT; c++)
            strobe("R4 R7 sweep", int'(model[p*TOT + c]), TOT - 1 - c);
      strobe("R8 sweep end", 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < NP*TOT; k++) model[k] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 rd_left", int'(rd_left), 0);
      chk("R1 wbuf_count", int'(wbuf_count), 0);
      // R7 first strobe after reset fetches page 0 column 0
      strobe("R7 after reset", 8'hFF, TOT - 1);

      // R2 overfill
      push_n(TOT + 2, 1);
      chk("R2 count caps", int'(wbuf_count), TOT);
      do_prog(1, 0);
      chk("R2 consumed", int'(wbuf_count), 0);
      do_load(1, 0);
      chk("R5 left col0", int'(rd_left), TOT);
      for (int c = 0; c < TOT; c++)
         strobe("R3 R6 page1", int'(model[TOT + c]), TOT - 1 - c);

      // R3 AND into overlap, tail past row end dropped
      push_n(10, 2);
      do_prog(1, TOT - 6);
      do_load(1, TOT - 13);
      chk("R5 left mid", int'(rd_left), 13);
      for (int c = TOT - 13; c < TOT; c++)
         strobe("R3 and", int'(model[TOT + c]), TOT - 1 - c);

      push_n(TOT, 3); do_prog(2, 0);
      push_n(20, 4);  do_prog(3, 4);

      // R7 reload keeps start column across pages, R8 after last page
      do_load(1, TOT - 2);
      strobe("R6 tail", int'(model[TOT + TOT - 2]), 1);
      strobe("R6 tail", int'(model[TOT + TOT - 1]), 0);
      strobe("R7 reload p2", int'(model[2*TOT + TOT - 2]), 1);
      strobe("R6 p2", int'(model[2*TOT + TOT - 1]), 0);
      strobe("R7 reload p3", int'(model[3*TOT + TOT - 2]), 1);
      strobe("R6 p3", int'(model[3*TOT + TOT - 1]), 0);
      strobe("R8 past end", 0, 0);
      strobe("R8 past end again", 0, 0);

      // R9 out-of-range operands
      push_n(5, 5);
      do_prog(NP, 0);
      chk("R9 buffer kept", int'(wbuf_count), 5);
      do_erase(NP + 1);
      do_load(NP + 2, 0);
      chk("R9 load ignored", int'(rd_left), 0);
      do_load(0, TOT);
      chk("R5 bad col ignored", int'(rd_left), 0);

      // R11 requests during busy
      @(negedge clk); erase_req = 1'b1; op_page = PG_W'(1);
      @(negedge clk); erase_req = 1'b0;
      for (int p = 0; p < 2; p++)
         for (int c = 0; c < TOT; c++) model[p*TOT + c] = 8'hFF;
      chk("R10 erase busy", int'(busy), 1);
      prog_req = 1'b1; load_req = 1'b1; op_page = PG_W'(2); op_col = '0;
      @(negedge clk); prog_req = 1'b0; load_req = 1'b0;
      chk("R11 load ignored", int'(rd_left), 0);
      while (busy) @(negedge clk);
      chk("R11 prog ignored", int'(wbuf_count), 5);
      @(negedge clk);
      chk("R11 no restart", int'(busy), 0);
      @(negedge clk); wbuf_clear = 1'b1;
      @(negedge clk); wbuf_clear = 1'b0; wcnt = 0;
      chk("R2 clear", int'(wbuf_count), 0);

      // R4 block 0 erased, block 1 intact
      sweep_all();
      do_erase(3);
      sweep_all();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule